// File: doc/BRIEF.md
# Subrate Switching Data Buffer

This block is the data store of a time-slot interchanger that can switch pieces smaller than a byte. Each word of the buffer is held as eight one-bit columns, and each column has its own write enable. An incoming byte arrives with a 7-bit tag extension. The tag picks one piece of that byte (the whole byte, a nibble, a dibit or a single bit) and the position in the addressed word where the piece is placed. Columns outside that position keep their contents. Several writes, each from a different source byte, can therefore build one outgoing word. Reads always return the whole byte.

A control bit named `sub_en` switches the subrate behaviour on. While `sub_en` is low, the tag is ignored and every write stores the full byte. The write side is a valid/ready stream, but `wr_ready` is always high, so the block never applies back-pressure: every cycle with `wr_valid` high is one accepted write. The read port is a plain registered port. It samples `rd_addr` on every clock edge.

Top module: `subrate_buf`

## Requirements
- R1: While `rst_n` is low, `rd_data` is 0 and `tag_err` is 0.
- R2: With `sub_en`=0, an accepted write stores all 8 bits of `wr_data` at `wr_addr`, whatever the value of `wr_tag`.
- R3: With `sub_en`=1, tag bit 6 = 0 and both 3-bit fields (source `wr_tag[5:3]`, destination `wr_tag[2:0]`) equal to 000 or 001, the full byte is written.
- R4: With `sub_en`=1, tag bit 6 = 0 and both fields equal to 01i, source nibble s is written to destination nibble d. Nibble i occupies bits 4i+3..4i, and s and d are the low bits of the source and destination fields. The other nibble of the word is kept.
- R5: With `sub_en`=1, tag bit 6 = 0 and both fields equal to 1kk, source dibit s is written to destination dibit d. Dibit k occupies bits 2k+1..2k, and s and d are the low two bits of the source and destination fields. The other six bits of the word are kept.
- R6: With `sub_en`=1 and tag bit 6 = 1, source bit `wr_tag[5:3]` of `wr_data` is written to bit `wr_tag[2:0]` of the word. The other seven bits are kept. All 64 combinations are legal.
- R7: With `sub_en`=1 and tag bit 6 = 0, a write whose two fields have different granularities (byte, nibble or dibit) changes nothing. It makes `tag_err` high for exactly the one cycle after the write. `tag_err` is low at all other times.
- R8: `rd_data` shows the word at the `rd_addr` sampled on the previous edge. A read in the same cycle as a write to that address returns the old word. A read in the next cycle returns the updated word.
- R9: `wr_ready` is always 1. The block never back-pressures the write stream.
- R10: A cycle with `wr_valid`=0 changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sub_en | input | 1 | Subrate enable; 0 = plain byte buffer |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write accept, always 1 |
| wr_addr | input | AW | Write word address |
| wr_data | input | 8 | Incoming source byte |
| wr_tag | input | 7 | Tag extension: [6] bit mode, [5:3] source, [2:0] destination |
| rd_addr | input | AW | Read word address |
| rd_data | output | 8 | Registered read word |
| tag_err | output | 1 | One-cycle pulse after an illegal-tag write |

## Verification
A write takes effect on the clock edge that accepts it. `rd_data` and `tag_err` both change on that same edge and hold for one cycle. The bench drives each cycle's inputs on the falling edge and samples both outputs just after the next rising edge. It compares `rd_data` with its model's word from before that cycle's write, which is how the same-cycle old-data rule of R8 is checked. It then applies the write to the model, so a read in the following cycle must return the merged word.

// File: rtl/subrate_pkg.sv
package subrate_pkg;
  typedef enum logic [1:0] {G_BYTE, G_NIB, G_DIB, G_BIT} gran_t;

  function automatic gran_t field_gran(input logic bitmode, input logic [2:0] f);
    if (bitmode)      return G_BIT;
    else if (f[2])    return G_DIB;
    else if (f[1])    return G_NIB;
    else              return G_BYTE;
  endfunction
endpackage

// File: rtl/subrate_tag_decode.sv
module subrate_tag_decode
  import subrate_pkg::*;
(
  input  logic [6:0] tag,
  output gran_t      gran,
  output logic [2:0] src_idx,
  output logic [2:0] dst_idx,
  output logic       legal
);
  gran_t src_g, dst_g;

  always_comb begin
    src_g   = field_gran(tag[6], tag[5:3]);
    dst_g   = field_gran(tag[6], tag[2:0]);
    legal   = (src_g == dst_g);
    gran    = dst_g;
    src_idx = tag[5:3];
    dst_idx = tag[2:0];
  end
endmodule

// File: rtl/subrate_lane_router.sv
module subrate_lane_router
  import subrate_pkg::*;
(
  input  logic       wr_valid,
  input  logic       sub_en,
  input  logic [7:0] wr_data,
  input  gran_t      gran,
  input  logic [2:0] src_idx,
  input  logic [2:0] dst_idx,
  input  logic       legal,
  output logic [7:0] col_we,
  output logic [7:0] col_din
);
  for (genvar c = 0; c < 8; c++) begin : g_lane
    localparam logic [2:0] CI = 3'(c);
    logic       hit;
    logic [2:0] sb;

    always_comb begin
      unique case (gran)
        G_BYTE: begin hit = 1'b1;                   sb = CI;                   end
        G_NIB:  begin hit = (CI[2] == dst_idx[0]);    sb = {src_idx[0], CI[1:0]}; end
        G_DIB:  begin hit = (CI[2:1] == dst_idx[1:0]); sb = {src_idx[1:0], CI[0]}; end
        default: begin hit = (CI == dst_idx);        sb = src_idx;              end
      endcase
      if (!sub_en) begin
        col_we[c]  = wr_valid;
        col_din[c] = wr_data[c];
      end else begin
        col_we[c]  = wr_valid && legal && hit;
        col_din[c] = wr_data[sb];
      end
    end
  end
endmodule

// File: rtl/subrate_column.sv
module subrate_column #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          din,
  input  logic [AW-1:0] raddr,
  output logic          dout
);
  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= 1'b0;
    else        dout <= mem[raddr];
  end
endmodule

// File: rtl/subrate_buf.sv
module subrate_buf
  import subrate_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sub_en,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [6:0]    wr_tag,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          tag_err
);
  gran_t      gran;
  logic [2:0] src_idx, dst_idx;
  logic       legal;
  logic [7:0] col_we, col_din;

  assign wr_ready = 1'b1;

  subrate_tag_decode u_dec (
    .tag(wr_tag), .gran(gran), .src_idx(src_idx), .dst_idx(dst_idx), .legal(legal)
  );

  subrate_lane_router u_route (
    .wr_valid(wr_valid), .sub_en(sub_en), .wr_data(wr_data), .gran(gran),
    .src_idx(src_idx), .dst_idx(dst_idx), .legal(legal),
    .col_we(col_we), .col_din(col_din)
  );

  for (genvar c = 0; c < 8; c++) begin : g_col
    subrate_column #(.DEPTH(DEPTH)) u_col (
      .clk(clk), .rst_n(rst_n), .we(col_we[c]), .waddr(wr_addr),
      .din(col_din[c]), .raddr(rd_addr), .dout(rd_data[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag_err <= 1'b0;
    else        tag_err <= wr_valid && sub_en && !legal;
  end

  // R2
  plain_full_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !sub_en) |-> (col_we == 8'hFF));
  // R6
  bit_single_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && sub_en && wr_tag[6]) |-> ($countones(col_we) == 1));
  // R4
  nibble_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && sub_en && !wr_tag[6] && wr_tag[5:4] == 2'b01 && wr_tag[2:1] == 2'b01)
      |-> ($countones(col_we) == 4));
  // R7
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && sub_en && col_we == 8'h00) |=> tag_err);
  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_err |-> $past(wr_valid && sub_en));
  // R10
  idle_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> (col_we == 8'h00));
endmodule

// File: tb/sim_subrate_buf.sv
`timescale 1ns/1ps
module sim_subrate_buf;
  localparam int DEPTH = 512;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0, sub_en = 0, wr_valid = 0;
  logic wr_ready, tag_err;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic [6:0] wr_tag = '0;

  int checks = 0, errors = 0;
  logic [7:0] model [DEPTH];
  bit known [DEPTH];

  always #5 clk = ~clk;

  subrate_buf #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .sub_en(sub_en), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_tag(wr_tag), .rd_addr(rd_addr),
    .rd_data(rd_data), .tag_err(tag_err)
  );

  function automatic int gr(input logic m, input logic [2:0] f);
    if (m) return 3;
    if (f[2]) return 2;
    if (f[1]) return 1;
    return 0;
  endfunction

  function automatic bit bad_tag(input logic [6:0] t);
    return gr(t[6], t[5:3]) != gr(t[6], t[2:0]);
  endfunction

  function automatic logic [7:0] merge(input logic [7:0] old, input logic [7:0] d,
                                       input logic [6:0] t);
    int w, s, ds;
    logic [7:0] r;
    case (gr(t[6], t[2:0]))
      0: begin w = 8; s = 0;              ds = 0;              end
      1: begin w = 4; s = int'(t[3]);     ds = int'(t[0]);     end
      2: begin w = 2; s = int'(t[4:3]);   ds = int'(t[1:0]);   end
      default: begin w = 1; s = int'(t[5:3]); ds = int'(t[2:0]); end
    endcase
    r = old;
    for (int i = 0; i < w; i++) r[ds*w + i] = d[s*w + i];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input int a, input logic [7:0] d, input logic [6:0] t,
                     input bit se, input int ra, input string req);
    logic [7:0] exp_rd;
    bit exp_err, kn;
    @(negedge clk);
    wr_valid = v; wr_addr = AW'(a); wr_data = d; wr_tag = t; sub_en = se; rd_addr = AW'(ra);
    exp_rd = model[ra]; kn = known[ra];
    exp_err = v && se && bad_tag(t);
    @(posedge clk); #1;
    if (kn) check(rd_data === exp_rd, req, int'(rd_data), int'(exp_rd));
    check(tag_err === exp_err, "R7", int'(tag_err), int'(exp_err));
    check(wr_ready === 1'b1, "R9", int'(wr_ready), 1);
    if (v) begin
      if (!se) begin model[a] = d; known[a] = 1; end
      else if (!bad_tag(t)) begin
        model[a] = merge(model[a], d, t);
        if (!t[6] && t[5:4] == 2'b00) known[a] = 1;
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    #1;
    check(rd_data === 8'h00, "R1", int'(rd_data), 0);
    check(tag_err === 1'b0, "R1", int'(tag_err), 0);
    @(negedge clk); rst_n = 1;

    // R2: plain fill with random tags, tag ignored
    for (int a = 0; a < DEPTH; a++)
      cyc(1, a, 8'(a * 37 + 11), 7'($urandom), 0, (a == 0) ? 0 : a - 1, "R2");
    cyc(1, 3, 8'h5A, 7'b0_011_100, 0, 3, "R8");   // illegal-looking tag ignored
    cyc(0, 0, 8'h00, 7'h00, 0, 3, "R2");

    // R3 byte in subrate mode
    cyc(1, 5, 8'hA5, 7'b0_001_000, 1, 5, "R8");
    cyc(0, 0, 8'h00, 7'h00, 1, 5, "R3");
    // R4 upper source nibble -> lower dest nibble
    cyc(1, 6, 8'hC3, 7'b0_011_010, 1, 6, "R8");
    cyc(0, 0, 8'h00, 7'h00, 1, 6, "R4");
    // R5 dibit 3 -> dibit 0, then dibit 0 -> dibit 2
    cyc(1, 7, 8'b1000_0001, 7'b0_111_100, 1, 7, "R8");
    cyc(0, 0, 8'h00, 7'h00, 1, 7, "R5");
    cyc(1, 7, 8'b0000_0011, 7'b0_100_110, 1, 7, "R8");
    cyc(0, 0, 8'h00, 7'h00, 1, 7, "R5");
    // R6 bit 7 -> bit 0, bit 0 -> bit 7
    cyc(1, 8, 8'h80, 7'b1_111_000, 1, 8, "R8");
    cyc(0, 0, 8'h00, 7'h00, 1, 8, "R6");
    cyc(1, 8, 8'h00, 7'b1_000_111, 1, 8, "R8");
    cyc(0, 0, 8'h00, 7'h00, 1, 8, "R6");
    // R7 mismatched nibble/dibit
    cyc(1, 9, 8'hFF, 7'b0_010_100, 1, 9, "R8");
    cyc(0, 0, 8'h00, 7'h00, 1, 9, "R7");
    // R10 idle write lines
    cyc(0, 9, 8'h00, 7'b0_000_000, 0, 9, "R10");
    cyc(0, 0, 8'h00, 7'h00, 0, 9, "R10");

    // random mix on a small address window
    for (int i = 0; i < 4000; i++) begin
      int a, ra;
      a  = int'($urandom_range(0, 15));
      ra = ($urandom_range(0, 1) == 1) ? int'(wr_addr) : int'($urandom_range(0, 15));
      cyc($urandom_range(0, 9) != 0, a, 8'($urandom), 7'($urandom),
          $urandom_range(0, 4) != 0, ra, "R8");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule